// File: doc/BRIEF.md
# Inversion-Controlled 32-bit Arithmetic Logic Unit

This block is a purely combinational integer ALU with 32-bit operands. A 4-bit operation code selects the result. The upper two bits of the code each invert one operand: bit 3 inverts `a` and bit 2 inverts `b`. Bit 2 also injects a carry of one into the adder. The lower two bits pick one tap from a single shared stage: the bitwise AND, the bitwise OR, the sum, or a less-than flag.

Each supported operation comes from this arrangement:
- subtraction is addition with `b` inverted and a carry-in of one;
- NOR is the AND of both inverted operands;
- the signed comparison takes the sign of the difference and corrects it with the overflow bit.

A zero flag reports an all-zero result. A branch-if-equal decision can read it after a subtraction.

Codes outside the supported set drive a zero result.

Top module: `inv_alu`

## Requirements
- R1: Code 4'b0000 drives `res` to `a & b`.
- R2: Code 4'b0001 drives `res` to `a | b`.
- R3: Code 4'b0010 drives `res` to `a + b` modulo 2^32. The carry out is discarded.
- R4: Code 4'b0110 drives `res` to `a - b` modulo 2^32. It is formed as `a + ~b + 1`.
- R5: Code 4'b0111 sets `res[0]` to 1 when `a < b` as signed two's-complement values and to 0 otherwise. Bits 31:1 are 0. The answer is correct when the difference overflows, for example with `a` = 32'h8000_0000 and `b` = 32'h0000_0001.
- R6: Code 4'b1100 drives `res` to `~(a | b)`.
- R7: `zf` is 1 exactly when all 32 bits of `res` are 0. After code 4'b0110 it is therefore 1 exactly when `a == b`.
- R8: Every other code (for example 4'b0011, 4'b0100, 4'b1000, 4'b1111) drives `res` to 0, and therefore `zf` to 1.
- R9: The block holds no state. `res` and `zf` follow `a`, `b` and `op` within the same cycle, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op | input | 4 | Operation code: [3] invert a, [2] invert b and carry-in, [1:0] tap select |
| res | output | 32 | Result |
| zf | output | 1 | High when `res` is all zero |

## Verification
The bench targets the signed comparison where the subtraction overflows. A comparator that reads only the raw sign of the difference reports 32'h8000_0000 < 1 as false and 32'h7FFF_FFFF < -1 as true. Subtraction with a missing carry-in is off by one, so equal operands leave the zero flag low. Wrap-around of the sum is checked at 32'hFFFF_FFFF + 1. Unsupported codes are checked for a nonzero result, which would appear if the invert bits leaked through with an otherwise valid tap.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [1:0] {
    TAP_AND  = 2'b00,
    TAP_OR   = 2'b01,
    TAP_SUM  = 2'b10,
    TAP_LESS = 2'b11
  } tap_e;

  typedef struct packed {
    logic inv_a;
    logic inv_b;
    tap_e tap;
    logic legal;
  } alu_ctl_t;
endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output alu_ctl_t        ctl
);
  always_comb begin
    ctl.inv_a = op[3];
    ctl.inv_b = op[2];
    ctl.tap   = tap_e'(op[1:0]);
    unique case (op)
      4'b0000, 4'b0001, 4'b0010,
      4'b0110, 4'b0111, 4'b1100: ctl.legal = 1'b1;
      default:                   ctl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned W = 32
) (
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] ca,
  output logic [W-1:0] cb,
  output logic [W-1:0] sum,
  output logic         lt
);
  localparam int unsigned MSB = W - 1;

  logic [W:0] wide;
  logic       ovf;

  always_comb begin
    ca   = inv_a ? ~a : a;
    cb   = inv_b ? ~b : b;
    // The carry-in is tied to the b-invert bit.
    wide = {1'b0, ca} + {1'b0, cb} + {{W{1'b0}}, inv_b};
    sum  = wide[W-1:0];
    ovf  = (ca[MSB] == cb[MSB]) && (sum[MSB] != ca[MSB]);
    lt   = sum[MSB] ^ ovf;
  end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  tap_e         tap,
  input  logic         legal,
  input  logic [W-1:0] ca,
  input  logic [W-1:0] cb,
  input  logic [W-1:0] sum,
  input  logic         lt,
  output logic [W-1:0] res
);
  logic [W-1:0] less_vec;

  assign less_vec = {{(W-1){1'b0}}, lt};

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic pick;
    always_comb begin
      unique case (tap)
        TAP_AND:  pick = ca[i] & cb[i];
        TAP_OR:   pick = ca[i] | cb[i];
        TAP_SUM:  pick = sum[i];
        default:  pick = less_vec[i];
      endcase
    end
    assign res[i] = pick & legal;
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);
  assign is_zero = ~|val;
endmodule

// File: rtl/inv_alu.sv
module inv_alu
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [OP_W-1:0] op,
  output logic [W-1:0]    res,
  output logic            zf
);
  alu_ctl_t     ctl;
  logic [W-1:0] ca;
  logic [W-1:0] cb;
  logic [W-1:0] sum;
  logic         lt;

  alu_ctrl_decode u_dec (.op(op), .ctl(ctl));

  alu_arith #(.W(W)) u_arith (
    .inv_a(ctl.inv_a), .inv_b(ctl.inv_b), .a(a), .b(b),
    .ca(ca), .cb(cb), .sum(sum), .lt(lt)
  );

  alu_result_mux #(.W(W)) u_mux (
    .tap(ctl.tap), .legal(ctl.legal), .ca(ca), .cb(cb),
    .sum(sum), .lt(lt), .res(res)
  );

  alu_zero_detect #(.W(W)) u_zero (.val(res), .is_zero(zf));
endmodule

// File: rtl/inv_alu_chk.sv
module inv_alu_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   op,
  input logic [W-1:0] res,
  input logic         zf
);
  always_comb begin
    if (op == 4'b0000) begin
      assert_and_R1: assert (((res & ~a) | (res & ~b)) == '0);
    end
    if (op == 4'b0001) begin
      assert_or_R2: assert (((a | b) & ~res) == '0);
    end
    if (op == 4'b0010) begin
      assert_add_R3: assert ((res - b) == a);
    end
    if (op == 4'b0110) begin
      assert_sub_R4: assert ((res + b) == a);
    end
    if (op == 4'b0111) begin
      assert_slt_shape_R5: assert (res[W-1:1] == '0);
    end
    if (op == 4'b1100) begin
      assert_nor_R6: assert ((res & (a | b)) == '0);
    end
    if (zf) begin
      assert_zero_R7: assert (res == '0);
    end
    if (!(op inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100})) begin
      assert_illegal_R8: assert (res == '0 && zf);
    end
  end
endmodule

bind inv_alu inv_alu_chk #(.W(W)) u_chk (
  .a(a), .b(b), .op(op), .res(res), .zf(zf)
);

// File: tb/sim_inv_alu.sv
module sim_inv_alu;
  logic        clk;
  logic [31:0] a;
  logic [31:0] b;
  logic [3:0]  op;
  logic [31:0] res;
  logic        zf;
  int          n_cmp;
  int          n_bad;
  bit          done;

  inv_alu u0 (.a(a), .b(b), .op(op), .res(res), .zf(zf));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [3:0] c);
    case (c)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b1100: return ~(x | y);
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input string tag, input logic [31:0] x, input logic [31:0] y,
                       input logic [3:0] c);
    logic [31:0] er;
    @(negedge clk);
    a = x; b = y; op = c;
    #2;
    er = model(x, y, c);
    n_cmp++;
    if (res !== er) begin
      n_bad++;
      $display("FAIL %s res op=%b a=%h b=%h actual=%h expected=%h", tag, c, x, y, res, er);
    end
    n_cmp++;
    if (zf !== (er == 32'd0)) begin
      n_bad++;
      $display("FAIL R7 zf (%s) op=%b actual=%b expected=%b", tag, c, zf, er == 32'd0);
    end
  endtask

  task automatic t_initial();
    apply("R9", 32'd0, 32'd0, 4'b0000);
  endtask

  task automatic t_logic();
    apply("R1", 32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000);
    apply("R1", 32'hFFFF_FFFF, 32'hA5A5_5A5A, 4'b0000);
    apply("R2", 32'hF000_0001, 32'h0000_0F10, 4'b0001);
    apply("R2", 32'd0, 32'd0, 4'b0001);
    apply("R6", 32'h1234_5678, 32'h0F0F_0000, 4'b1100);
    apply("R6", 32'hFFFF_0000, 32'h0000_FFFF, 4'b1100);
  endtask

  task automatic t_arith();
    apply("R3", 32'd17, 32'd25, 4'b0010);
    apply("R3", 32'hFFFF_FFFF, 32'd1, 4'b0010);
    apply("R3", 32'h7FFF_FFFF, 32'd1, 4'b0010);
    apply("R4", 32'd100, 32'd58, 4'b0110);
    apply("R4", 32'd0, 32'd1, 4'b0110);
    apply("R4", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0110);
  endtask

  task automatic t_slt();
    apply("R5", 32'd3, 32'd9, 4'b0111);
    apply("R5", 32'd9, 32'd3, 4'b0111);
    apply("R5", 32'd5, 32'd5, 4'b0111);
    apply("R5", 32'hFFFF_FFFF, 32'd0, 4'b0111);
    apply("R5", 32'h8000_0000, 32'd1, 4'b0111);
    apply("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
    apply("R5", 32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);
  endtask

  task automatic t_illegal();
    apply("R8", 32'hFFFF_FFFF, 32'h1234_5678, 4'b0011);
    apply("R8", 32'hFFFF_FFFF, 32'h1234_5678, 4'b0100);
    apply("R8", 32'h0000_0001, 32'h0000_0002, 4'b1000);
    apply("R8", 32'hAAAA_AAAA, 32'h5555_5555, 4'b1111);
    apply("R8", 32'd7, 32'd9, 4'b1110);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    a = '0; b = '0; op = '0;
    t_initial();
    t_logic();
    t_arith();
    t_slt();
    t_illegal();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule